// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares a reference input against a feedback input inside one system clock domain and tells a downstream charge pump or digital loop filter which way to steer. Each input is first brought into the clock domain by a two-flop synchronizer. A third flop then detects the rising edge. Only those rising edges change the detector, so the duty cycle of either input makes no difference. The detector keeps one pending-edge flag per input. A reference edge raises the up command. A feedback edge raises the down command. When both flags would be set, both clear together.

The command outputs take three states: up, down, or hold (neither). The hold output is high whenever no correction is being applied, so it also works as a phase pulse for the lock indication. A separate lock output rises after a programmable number of consecutive reference edges during which no correction lasted longer than one system clock. It drops as soon as a longer correction appears.

Top module: `edge_pfd_top`

## Requirements
- R1: A rising edge on an input reaches the detector state on the third rising clock edge after the input first reads high at a clock edge. Falling edges and the width of the high phase have no effect on up_o or dn_o.
- R2: A reference edge with no feedback edge pending raises up_o, and up_o stays high until the next feedback edge is seen.
- R3: A feedback edge with no reference edge pending raises dn_o, and dn_o stays high until the next reference edge is seen.
- R4: up_o and dn_o are never high in the same cycle. Reference and feedback edges seen in the same cycle produce no up or down pulse.
- R5: When both inputs run at the same frequency, the correction lasts exactly the phase offset in clock cycles. up_o is used when feedback lags, and dn_o when the reference lags.
- R6: If the reference runs faster than the feedback, up_o is high for most cycles and dn_o never rises. If the reference runs slower, the roles swap.
- R7: hold_o is high exactly in the cycles where both up_o and dn_o are low.
- R8: lock_o rises on the N-th consecutive qualifying reference edge, where N = lock_periods. A value of 0 is treated as 1. lock_o rises three clock edges after that reference input goes high.
- R9: A correction that stays active for two consecutive cycles drops lock_o on the next clock edge and restarts the count. Single-cycle corrections leave lock_o and the count intact.
- R10: A synchronous active-high reset clears the synchronizers, flags and lock count. The next cycle shows up_o=0, dn_o=0, hold_o=1 and lock_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both inputs |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback (comparator) signal, asynchronous |
| lock_periods | input | CNT_W | Number of consecutive clean reference edges required for lock |
| up_o | output | 1 | Pump-up command |
| dn_o | output | 1 | Pump-down command |
| hold_o | output | 1 | High when no correction is active (phase pulse) |
| lock_o | output | 1 | Lock indication |

## Verification
The bench drives inputs at the falling clock edge and samples every output 1 ns after the rising edge. For a signal that goes high before rising edge 0, a command flag is due after edge 2, lock_o is due after edge 2, and a lock drop is due two edges after the start of a correction that lasts two cycles. The offset table measures the first cycle each command appears and compares it with the rise cycle plus two, and it also counts the total pulse width per row. The lock tests read lock_o one cycle before and exactly at the due edge, so an extra or missing register stage shows up as a miscompare.

// File: rtl/edge_pfd_pkg.sv
package edge_pfd_pkg;

    // pending-edge flags of the detector core
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

    localparam int NUM_CH = 2;
    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;

endpackage

// File: rtl/edge_pfd_sync.sv
module edge_pfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], din};
        if (rst) begin
            sh_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    // newest synchronized level against the previous one
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    p_edge_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/edge_pfd_core.sv
module edge_pfd_core
    import edge_pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_edge,
    input  logic fb_edge,
    output logic up_o,
    output logic dn_o
);
    pfd_flags_t fl_d, fl_q;

    always_comb begin
        fl_d.up = fl_q.up | ref_edge;
        fl_d.dn = fl_q.dn | fb_edge;
        if (fl_d.up && fl_d.dn) begin
            fl_d = '0;
        end
        if (rst) begin
            fl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        fl_q <= fl_d;
    end

    assign up_o = fl_q.up;
    assign dn_o = fl_q.dn;

    p_never_both_r4: assert property (@(posedge clk) disable iff (rst)
        !(fl_q.up && fl_q.dn));

    p_pair_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (ref_edge && fb_edge) |=> (!fl_q.up && !fl_q.dn));

    p_ref_sets_up_r2: assert property (@(posedge clk) disable iff (rst)
        (ref_edge && !fb_edge && !fl_q.dn) |=> fl_q.up);

    p_fb_sets_dn_r3: assert property (@(posedge clk) disable iff (rst)
        (fb_edge && !ref_edge && !fl_q.up) |=> fl_q.dn);

    p_up_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (fl_q.up && !fb_edge) |=> fl_q.up);

endmodule

// File: rtl/edge_pfd_lock.sv
module edge_pfd_lock #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge,
    input  logic             act_i,
    input  logic [CNT_W-1:0] lock_periods,
    output logic             lock_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             act_prev;
        logic [CNT_W-1:0] good;
        logic             lock;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic             long_pulse;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] inc;

    always_comb begin
        long_pulse = act_i && st_q.act_prev;
        need       = (lock_periods == '0) ? CNT_ONE : lock_periods;
        inc        = (st_q.good == CNT_MAX) ? st_q.good : st_q.good + CNT_ONE;
        st_d          = st_q;
        st_d.act_prev = act_i;
        if (long_pulse) begin
            st_d.good = '0;
            st_d.lock = 1'b0;
        end else if (ref_edge) begin
            st_d.good = inc;
            st_d.lock = st_q.lock | (inc >= need);
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lock_o = st_q.lock;

    p_long_drops_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (act_i && st_q.act_prev) |=> (!st_q.lock && st_q.good == '0));

    p_lock_needs_edge_r8: assert property (@(posedge clk) disable iff (rst)
        (!st_q.lock && !ref_edge) |=> !st_q.lock);

endmodule

// File: rtl/edge_pfd_top.sv
module edge_pfd_top
    import edge_pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [CNT_W-1:0] lock_periods,
    output logic             up_o,
    output logic             dn_o,
    output logic             hold_o,
    output logic             lock_o
);
    logic [NUM_CH-1:0] raw;
    logic [NUM_CH-1:0] rise;

    assign raw[CH_REF] = ref_in;
    assign raw[CH_FB]  = fb_in;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
        edge_pfd_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (clk),
            .rst    (rst),
            .din    (raw[g]),
            .rise_o (rise[g])
        );
    end

    edge_pfd_core i_core (
        .clk      (clk),
        .rst      (rst),
        .ref_edge (rise[CH_REF]),
        .fb_edge  (rise[CH_FB]),
        .up_o     (up_o),
        .dn_o     (dn_o)
    );

    edge_pfd_lock #(.CNT_W(CNT_W)) i_lock (
        .clk          (clk),
        .rst          (rst),
        .ref_edge     (rise[CH_REF]),
        .act_i        (up_o | dn_o),
        .lock_periods (lock_periods),
        .lock_o       (lock_o)
    );

    assign hold_o = ~(up_o | dn_o);

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (!up_o && !dn_o && !lock_o));

endmodule

// File: tb/test_edge_pfd_top.sv
`timescale 1ns/1ps
module test_edge_pfd_top;
    localparam int CNT_W = 8;
    localparam int VEC_N = 8;
    localparam int BASE  = 8;
    localparam int WIN   = 30;
    localparam int OFFS [VEC_N] = '{0, 1, 3, 5, -1, -4, -7, 2};
    localparam int RHI  [VEC_N] = '{2, 8, 4, 9, 6, 3, 8, 1};
    localparam int FHI  [VEC_N] = '{9, 8, 4, 2, 6, 3, 8, 5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic [CNT_W-1:0] lock_periods = 8'd4;
    logic up_o, dn_o, hold_o, lock_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    edge_pfd_top #(.CNT_W(CNT_W)) i_edge_pfd_top (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .lock_periods(lock_periods),
        .up_o(up_o), .dn_o(dn_o), .hold_o(hold_o), .lock_o(lock_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic f);
        @(negedge clk);
        ref_in = r;
        fb_in  = f;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one aligned-or-offset period with a lock probe per cycle
    task automatic lock_period(input int off, output logic lk [20]);
        for (int c = 0; c < 20; c++) begin
            step(c < 8, (c >= off) && (c < off + 8));
            lk[c] = lock_o;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic lk [20];
        int   n_up, n_dn, n_both, n_holdbad, first_up, first_dn;

        repeat (3) @(posedge clk);
        do_reset();
        @(posedge clk); #1;
        // R10 reset state
        chk(!up_o && !dn_o, "R10 cmd after reset", {up_o, dn_o}, 0);
        chk(hold_o === 1'b1, "R10 hold after reset", hold_o, 1);
        chk(lock_o === 1'b0, "R10 lock after reset", lock_o, 0);

        // offset table: R1 R2 R3 R4 R5 R7
        for (int v = 0; v < VEC_N; v++) begin
            int fr;
            fr = BASE + OFFS[v];
            n_up = 0; n_dn = 0; n_both = 0; n_holdbad = 0;
            first_up = -1; first_dn = -1;
            for (int c = 0; c < WIN; c++) begin
                step((c >= BASE) && (c < BASE + RHI[v]), (c >= fr) && (c < fr + FHI[v]));
                if (up_o) begin n_up++; if (first_up < 0) first_up = c; end
                if (dn_o) begin n_dn++; if (first_dn < 0) first_dn = c; end
                if (up_o && dn_o) n_both++;
                if (hold_o !== !(up_o || dn_o)) n_holdbad++;
            end
            chk(n_up == (OFFS[v] > 0 ? OFFS[v] : 0), "R5 up width", n_up, OFFS[v] > 0 ? OFFS[v] : 0);
            chk(n_dn == (OFFS[v] < 0 ? -OFFS[v] : 0), "R5 dn width", n_dn, OFFS[v] < 0 ? -OFFS[v] : 0);
            chk(n_both == 0, "R4 up and dn together", n_both, 0);
            chk(n_holdbad == 0, "R7 hold mismatch", n_holdbad, 0);
            if (OFFS[v] > 0)
                chk(first_up == BASE + 2, "R1 R2 up latency", first_up, BASE + 2);
            if (OFFS[v] < 0)
                chk(first_dn == fr + 2, "R1 R3 dn latency", first_dn, fr + 2);
        end

        // R6 fast reference: period 10 against feedback period 20
        do_reset();
        n_up = 0; n_dn = 0;
        for (int t = 0; t < 200; t++) begin
            step((t % 10) < 5, ((t + 15) % 20) < 10);
            if (up_o) n_up++;
            if (dn_o) n_dn++;
        end
        chk(n_up > 100, "R6 fast ref up majority", n_up, 101);
        chk(n_dn == 0, "R6 fast ref no dn", n_dn, 0);

        // R6 slow reference: the roles swap
        do_reset();
        n_up = 0; n_dn = 0;
        for (int t = 0; t < 200; t++) begin
            step(((t + 15) % 20) < 10, (t % 10) < 5);
            if (up_o) n_up++;
            if (dn_o) n_dn++;
        end
        chk(n_dn > 100, "R6 slow ref dn majority", n_dn, 101);
        chk(n_up == 0, "R6 slow ref no up", n_up, 0);

        // R8 lock after four aligned periods, due on edge 2 of the fourth
        do_reset();
        lock_periods = 8'd4;
        for (int p = 0; p < 3; p++) begin
            lock_period(0, lk);
            chk(lk[19] === 1'b0, "R8 lock before count", lk[19], 0);
        end
        lock_period(0, lk);
        chk(lk[1] === 1'b0, "R8 lock one cycle early", lk[1], 0);
        chk(lk[2] === 1'b1, "R8 lock at due edge", lk[2], 1);

        // R9 a single-cycle correction keeps lock
        lock_period(1, lk);
        chk(lk[19] === 1'b1, "R9 short pulse keeps lock", lk[19], 1);

        // R9 a three-cycle correction drops lock two edges after it starts
        lock_period(3, lk);
        chk(lk[3] === 1'b1, "R9 lock before drop", lk[3], 1);
        chk(lk[4] === 1'b0, "R9 lock drop edge", lk[4], 0);

        // R9 count restarts: three clean periods are not enough
        for (int p = 0; p < 3; p++) lock_period(0, lk);
        chk(lk[19] === 1'b0, "R9 count restarted", lk[19], 0);
        lock_period(0, lk);
        chk(lk[2] === 1'b1, "R9 relock", lk[2], 1);

        // R8 zero means one
        do_reset();
        lock_periods = 8'd0;
        lock_period(0, lk);
        chk(lk[2] === 1'b1, "R8 zero treated as one", lk[2], 1);

        // R10 reset in the middle of a correction
        do_reset();
        for (int c = 0; c < 6; c++) step(c < 3, 1'b0);
        chk(up_o === 1'b1, "R2 up pending", up_o, 1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk(!up_o && hold_o && !lock_o, "R10 reset clears", {up_o, hold_o, lock_o}, 2);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 6; c++) step(1'b0, 1'b0);
        chk(up_o === 1'b0 && dn_o === 1'b0, "R10 stays idle", {up_o, dn_o}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule